// File: doc/BRIEF.md
# Unattended power-on controller

This block decides when a system that sits with its power switch in the standby position should be powered up without an operator. Two hardware events can wake it: a one-cycle match pulse from the real-time clock's wake-up date comparator, and a one-cycle incoming-call pulse from a serial port. Each event source has its own enable. An accepted event latches a cause flag, raises an interrupt and, when the system is off, issues a one-cycle power-on request and turns the power enable on.

Software reaches two byte-wide control registers through a simple write/read port. The status register (select 0) holds the cause flags, the power-hold bit and plain storage bits for battery and tamper status. The enable register (select 1) holds the event enables, a tamper interrupt enable and plain storage bits for battery source and RAM clearing. While the switch is in standby, setting the power-hold bit to 1 turns the system off. While the switch is on, that bit has no effect on power.

Power sequencing is a four-state machine. OFF is standby with power off. REQUEST lasts one cycle and drives the power-on request. UNATTENDED is standby with power held on. SWITCHED is the switch in the on position. The named transitions are as follows. SW_ON goes from any state to SWITCHED when the switch reads on. EVENT goes from OFF to REQUEST on an accepted event. GRANT goes from REQUEST to UNATTENDED. RELEASE goes from UNATTENDED to OFF when the hold bit is 1. SW_OFF goes from SWITCHED to OFF when the switch leaves on with the hold bit at 1. HANDOFF goes from SWITCHED to UNATTENDED when the switch leaves on with the hold bit at 0.

Top module: `upwr_ctrl`

## Requirements
- R1: After reset both registers read 0x00, and pwr_req, pwr_en and irq are 0.
- R2: With the alarm enable (enable register bit 1) set and power off, an alarm_hit pulse sets the alarm flag (status bit 1). It also clears the hold bit (status bit 3) and drives pwr_req high for exactly the next cycle. pwr_en is 1 from that cycle on.
- R3: With the call enable (enable register bit 0) set and power off, a ring_hit pulse sets the call flag (status bit 0), clears the hold bit and gives the same one-cycle pwr_req with power on.
- R4: An event whose enable bit is 0 sets no flag, issues no request and leaves the power state unchanged.
- R5: irq is 1 exactly when some flag and its enable are both set. The pairs are: status bit 1 with enable bit 1, status bit 0 with enable bit 0, and the tamper status (status bit 2) with the tamper interrupt enable (enable bit 2).
- R6: Writing 0 to a cause flag clears it, and so removes its share of irq. Writing 1 to a cause flag leaves it unchanged. A hardware set in the same cycle as a clearing write wins.
- R7: In UNATTENDED, writing the hold bit to 1 turns pwr_en off at the second clock edge after the write is sampled.
- R8: With sw_on high, pwr_en is 1 from the next edge on. Writing the hold bit to 1 then leaves power on.
- R9: An enabled event that arrives while power is already on sets its flag but issues no pwr_req.
- R10: When sw_on falls in SWITCHED, power goes off at the next edge if the hold bit is 1. If the hold bit is 0, power stays on in UNATTENDED.
- R11: Status bits 7 and 2 and enable bits 7, 4 and 2 are plain read/write storage. Status bits 6:4 and enable bits 6:5 and 3 always read 0.
- R12: If an event power-on and a write of 1 to the hold bit fall in the same cycle, the hold bit ends at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alarm_hit | input | 1 | One-cycle wake-up date match pulse |
| ring_hit | input | 1 | One-cycle incoming-call pulse |
| sw_on | input | 1 | 1 = power switch on, 0 = standby |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 status, 1 enable |
| wr_data | input | 8 | Write data |
| rd_sel | input | 1 | Read source: 0 status, 1 enable |
| rd_data | output | 8 | Selected register contents (combinational) |
| pwr_req | output | 1 | One-cycle power-on request |
| pwr_en | output | 1 | System power enable |
| irq | output | 1 | Interrupt request |

## Verification
All register, flag and state changes land at the edge that samples the stimulus. So rd_data, irq, pwr_en and pwr_req reflect a write or an event one edge later, and the power-on request lasts exactly that one cycle. The only two-edge path is RELEASE: the hold bit is written at one edge and pwr_en falls at the next. The bench drives inputs on the falling edge. It advances a behavioural model at each rising edge from the inputs held there, and it compares every output at the following falling edge. Directed checks sample at those same falling edges.

// File: rtl/upwr_pkg.sv
package upwr_pkg;

    localparam int REG_W = 8;
    localparam int N_SRC = 2;

    // status register bit positions (software decodes these)
    localparam int ST_CALL  = 0;
    localparam int ST_ALARM = 1;
    localparam int ST_TAMP  = 2;
    localparam int ST_HOLD  = 3;
    localparam int ST_BATT  = 7;

    // enable register bit positions
    localparam int EN_CALL  = 0;
    localparam int EN_ALARM = 1;
    localparam int EN_TAMP  = 2;
    localparam int EN_CLR   = 4;
    localparam int EN_EXTB  = 7;

    localparam logic [REG_W-1:0] ST_STORE_MASK =
        REG_W'((1 << ST_BATT) | (1 << ST_TAMP));
    localparam logic [REG_W-1:0] EN_MASK =
        REG_W'((1 << EN_EXTB) | (1 << EN_CLR) | (1 << EN_TAMP) |
               (1 << EN_ALARM) | (1 << EN_CALL));

    typedef enum logic [1:0] {
        PS_OFF,
        PS_REQUEST,
        PS_UNATTENDED,
        PS_SWITCHED
    } pwr_state_t;

endpackage

// File: rtl/upwr_regs.sv
module upwr_regs
    import upwr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [REG_W-1:0] wr_data,
    input  logic [N_SRC-1:0] src_set,
    input  logic             hold_clr,
    output logic [REG_W-1:0] stat_o,
    output logic [REG_W-1:0] ena_o,
    output logic [N_SRC-1:0] flag_o,
    output logic             hold_o
);

    logic             wr_stat;
    logic             wr_ena;
    logic [REG_W-1:0] store_q;
    logic [REG_W-1:0] ena_q;
    logic             hold_q;

    assign wr_stat = wr_en && !wr_sel;
    assign wr_ena  = wr_en &&  wr_sel;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            store_q <= '0;
            ena_q   <= '0;
        end else begin
            if (wr_stat) store_q <= wr_data & ST_STORE_MASK;
            if (wr_ena)  ena_q   <= wr_data & EN_MASK;
        end
    end

    // hardware clear of the hold bit outranks a software write
    always_ff @(posedge clk) begin
        if (!rst_n)        hold_q <= 1'b0;
        else if (hold_clr) hold_q <= 1'b0;
        else if (wr_stat)  hold_q <= wr_data[ST_HOLD];
    end

    // one cause flag per event source; set has priority over clear
    for (genvar i = 0; i < N_SRC; i++) begin : g_flag
        logic f_q;
        always_ff @(posedge clk) begin
            if (!rst_n)                       f_q <= 1'b0;
            else if (src_set[i])              f_q <= 1'b1;
            else if (wr_stat && !wr_data[i])  f_q <= 1'b0;
        end
        assign flag_o[i] = f_q;
    end

    always_comb begin
        stat_o                 = store_q;
        stat_o[ST_HOLD]        = hold_q;
        stat_o[N_SRC-1:0]      = flag_o;
    end

    assign ena_o  = ena_q;
    assign hold_o = hold_q;

endmodule

// File: rtl/upwr_fsm.sv
module upwr_fsm
    import upwr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sw_on,
    input  logic wake_hit,
    input  logic hold,
    output logic grant,
    output logic pwr_req,
    output logic pwr_en
);

    pwr_state_t state_q;
    pwr_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_OFF: begin
                if (sw_on)         state_d = PS_SWITCHED;   // SW_ON
                else if (wake_hit) state_d = PS_REQUEST;    // EVENT
            end
            PS_REQUEST: begin
                if (sw_on) state_d = PS_SWITCHED;           // SW_ON
                else       state_d = PS_UNATTENDED;         // GRANT
            end
            PS_UNATTENDED: begin
                if (sw_on)     state_d = PS_SWITCHED;       // SW_ON
                else if (hold) state_d = PS_OFF;            // RELEASE
            end
            PS_SWITCHED: begin
                if (!sw_on) state_d = hold ? PS_OFF         // SW_OFF
                                           : PS_UNATTENDED; // HANDOFF
            end
            default: state_d = PS_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PS_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        grant   = 1'b0;
        pwr_req = 1'b0;
        pwr_en  = 1'b1;
        unique case (state_q)
            PS_OFF: begin
                pwr_en = 1'b0;
                grant  = !sw_on && wake_hit;
            end
            PS_REQUEST:    pwr_req = 1'b1;
            PS_UNATTENDED: pwr_en  = 1'b1;
            PS_SWITCHED:   pwr_en  = 1'b1;
            default:       pwr_en  = 1'b0;
        endcase
    end

endmodule

// File: rtl/upwr_ctrl.sv
module upwr_ctrl
    import upwr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alarm_hit,
    input  logic             ring_hit,
    input  logic             sw_on,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [REG_W-1:0] wr_data,
    input  logic             rd_sel,
    output logic [REG_W-1:0] rd_data,
    output logic             pwr_req,
    output logic             pwr_en,
    output logic             irq
);

    logic [N_SRC-1:0] src_evt;
    logic [N_SRC-1:0] src_ena;
    logic [N_SRC-1:0] src_hit;
    logic [N_SRC-1:0] flag_w;
    logic [REG_W-1:0] stat_w;
    logic [REG_W-1:0] ena_w;
    logic             hold_w;
    logic             grant_w;
    logic             tamp_w;

    // source index matches the flag and enable bit positions
    assign src_evt[ST_CALL]  = ring_hit;
    assign src_evt[ST_ALARM] = alarm_hit;
    assign src_ena           = ena_w[N_SRC-1:0];
    assign src_hit           = src_evt & src_ena;
    assign tamp_w            = stat_w[ST_TAMP];

    upwr_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .src_set  (src_hit),
        .hold_clr (grant_w),
        .stat_o   (stat_w),
        .ena_o    (ena_w),
        .flag_o   (flag_w),
        .hold_o   (hold_w)
    );

    upwr_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_on    (sw_on),
        .wake_hit (|src_hit),
        .hold     (hold_w),
        .grant    (grant_w),
        .pwr_req  (pwr_req),
        .pwr_en   (pwr_en)
    );

    assign rd_data = rd_sel ? ena_w : stat_w;
    assign irq     = (|(flag_w & src_ena)) || (tamp_w && ena_w[EN_TAMP]);

endmodule

// File: rtl/upwr_ctrl_chk.sv
module upwr_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sw_on,
    input logic       wr_en,
    input logic       wr_sel,
    input logic [1:0] wr_lo,
    input logic       pwr_req,
    input logic       pwr_en,
    input logic       irq,
    input logic       hold,
    input logic [1:0] flags,
    input logic       tamp
);

    p_req_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_req |=> !pwr_req);

    p_req_powered_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_req |-> pwr_en);

    p_req_from_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_req |-> $past(!pwr_en));

    p_switch_power_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sw_on |=> pwr_en);

    p_hold_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_en && !pwr_req && !sw_on && hold) |=> !pwr_en);

    p_alarm_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flags[1]) |-> $past(wr_en && !wr_sel && !wr_lo[1]));

    p_call_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flags[0]) |-> $past(wr_en && !wr_sel && !wr_lo[0]));

    p_irq_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flags != 2'b00 || tamp));

endmodule

bind upwr_ctrl upwr_ctrl_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sw_on   (sw_on),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_lo   (wr_data[1:0]),
    .pwr_req (pwr_req),
    .pwr_en  (pwr_en),
    .irq     (irq),
    .hold    (hold_w),
    .flags   (flag_w),
    .tamp    (tamp_w)
);

// File: tb/upwr_ctrl_test.sv
module upwr_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       alarm_hit = 1'b0;
    logic       ring_hit = 1'b0;
    logic       sw_on = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_sel = 1'b0;
    logic [7:0] rd_data;
    logic       pwr_req;
    logic       pwr_en;
    logic       irq;

    int checks = 0;
    int errors = 0;
    string phase = "R1";

    // behavioural model: 0 off, 1 request, 2 unattended, 3 switched
    int       m_state = 0;
    logic [7:0] m_stat = 8'h00;
    logic [7:0] m_ena  = 8'h00;

    always #5 clk = ~clk;

    upwr_ctrl uut (
        .clk(clk), .rst_n(rst_n), .alarm_hit(alarm_hit), .ring_hit(ring_hit),
        .sw_on(sw_on), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .pwr_req(pwr_req),
        .pwr_en(pwr_en), .irq(irq)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic model_edge();
        bit a_ok, c_ok, go;
        logic [7:0] ns;
        int nxt;
        if (!rst_n) begin
            m_state = 0; m_stat = 0; m_ena = 0;
            return;
        end
        a_ok = alarm_hit && m_ena[1];
        c_ok = ring_hit && m_ena[0];
        go   = (m_state == 0) && !sw_on && (a_ok || c_ok);
        ns   = m_stat;
        if (wr_en && !wr_sel) begin
            ns[7] = wr_data[7];
            ns[2] = wr_data[2];
            ns[3] = wr_data[3];
            if (!wr_data[1]) ns[1] = 1'b0;
            if (!wr_data[0]) ns[0] = 1'b0;
        end
        if (a_ok) ns[1] = 1'b1;
        if (c_ok) ns[0] = 1'b1;
        if (go)   ns[3] = 1'b0;
        if (sw_on) nxt = 3;
        else if (m_state == 0) nxt = go ? 1 : 0;
        else if (m_state == 1) nxt = 2;
        else nxt = m_stat[3] ? 0 : 2;
        if (wr_en && wr_sel) m_ena = wr_data & 8'h97;
        m_stat  = ns;
        m_state = nxt;
    endtask

    function automatic int m_irq();
        return int'((m_stat[1] & m_ena[1]) | (m_stat[0] & m_ena[0]) |
                    (m_stat[2] & m_ena[2]));
    endfunction

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check({phase, " pwr_req"}, int'(pwr_req), int'(m_state == 1));
        check({phase, " pwr_en"},  int'(pwr_en),  int'(m_state != 0));
        check({phase, " irq"},     int'(irq),     m_irq());
        check({phase, " rd_data"}, int'(rd_data), int'(rd_sel ? m_ena : m_stat));
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic rdchk(input logic sel, input int exp, input string tag);
        rd_sel = sel;
        #1;
        check(tag, int'(rd_data), exp);
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        step(); step();
        rst_n = 1'b1;
        step();
        phase = "R1";
        rdchk(0, 0, "R1 status"); rdchk(1, 0, "R1 enable");
        check("R1 pwr_en", int'(pwr_en), 0);
        check("R1 irq", int'(irq), 0);
        rd_sel = 0;

        phase = "R2";
        wr(1, 8'h02);
        alarm_hit = 1; step(); alarm_hit = 0;
        check("R2 request", int'(pwr_req), 1);
        check("R5 irq alarm", int'(irq), 1);
        step();
        check("R2 request single", int'(pwr_req), 0);
        check("R2 power", int'(pwr_en), 1);
        rdchk(0, 8'h02, "R2 status");

        phase = "R6";
        wr(0, 8'h02);
        rdchk(0, 8'h02, "R6 write one keeps flag");
        wr(0, 8'h00);
        rdchk(0, 8'h00, "R6 write zero clears");
        check("R6 irq dropped", int'(irq), 0);

        phase = "R7";
        wr(0, 8'h08);
        check("R7 still on", int'(pwr_en), 1);
        step();
        check("R7 off", int'(pwr_en), 0);

        phase = "R4";
        ring_hit = 1; step(); ring_hit = 0;
        check("R4 no request", int'(pwr_req), 0);
        step();
        check("R4 stays off", int'(pwr_en), 0);
        rdchk(0, 8'h08, "R4 no flag");

        phase = "R3";
        wr(1, 8'h01);
        ring_hit = 1; step(); ring_hit = 0;
        check("R3 request", int'(pwr_req), 1);
        step();
        rdchk(0, 8'h01, "R3 status");

        phase = "R9";
        wr(1, 8'h03);
        alarm_hit = 1; step(); alarm_hit = 0;
        check("R9 no request unattended", int'(pwr_req), 0);
        rdchk(0, 8'h03, "R9 flag set");

        phase = "R8";
        sw_on = 1; step();
        check("R8 switched on", int'(pwr_en), 1);
        wr(0, 8'h0B);
        step(); step();
        check("R8 hold ignored", int'(pwr_en), 1);

        phase = "R9";
        wr(0, 8'h08);
        ring_hit = 1; step(); ring_hit = 0;
        check("R9 no request switched", int'(pwr_req), 0);
        rdchk(0, 8'h09, "R9 call flag");

        phase = "R10";
        sw_on = 0; step();
        check("R10 off with hold", int'(pwr_en), 0);
        sw_on = 1; step();
        wr(0, 8'h00);
        sw_on = 0; step();
        check("R10 handoff keeps power", int'(pwr_en), 1);
        step();
        check("R10 still on", int'(pwr_en), 1);
        wr(0, 8'h08);
        step();
        check("R10 released", int'(pwr_en), 0);

        phase = "R12";
        alarm_hit = 1; wr(0, 8'h08); alarm_hit = 0;
        check("R12 request", int'(pwr_req), 1);
        rdchk(0, 8'h02, "R12 hold forced low");

        phase = "R11";
        wr(1, 8'hFF);
        rdchk(1, 8'h97, "R11 enable storage");
        wr(0, 8'hF4);
        rdchk(0, 8'h84, "R11 status storage");
        check("R5 tamper irq", int'(irq), 1);
        wr(1, 8'h03);
        check("R5 tamper masked", int'(irq), 0);
        rd_sel = 0;
        step(); step();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule